// File: doc/BRIEF.md
# Lock-Bit Command Controller

This block is the command state machine that manages the protection bits of a memory organised in blocks. It takes bus write cycles, each made of a command byte and an address, and runs three protected operations. It can set the lock bit of one block, set one global "freeze" bit that can never be undone, or clear every block lock bit at once. Each of these operations needs two writes: a setup byte and then a confirm byte. The lock bits themselves are modelled as registers inside the block.

Two qualifiers gate every operation. The first is a high-voltage reset-pin input (`hv_rst`), and the second is a program-voltage-valid input (`vpp_ok`). When an operation fails, the block sets a combination of sticky error bits that depends on the cause. Once the setup byte has been accepted, reads return an 8-bit status word. An operation keeps the block busy for a fixed number of cycles, and the `ready` output shows when it has finished.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `rd_data` is 0x00, and no block lock bit or freeze bit is set.
- R2: The status word carries ready in bit 7, clear-error in bit 5, set-error in bit 4, voltage-low in bit 3 and protect-error in bit 1. Bits 6, 2 and 0 read 0. Writing 0x70 or 0x60 from idle selects status reads, and `rd_data` then shows the status word. Any other byte written from idle, except 0x50, selects array reads, and `rd_data` then shows 0x00.
- R3: The setup byte 0x60 must be followed by one of three confirm bytes. 0x01 sets the lock of one block, 0xF1 sets the freeze bit, and 0xD0 clears all block locks. Any other second byte sets bits 5 and 4, changes no lock, never drops `ready`, and leaves status reads selected.
- R4: A confirm byte drops `ready` (and status bit 7) for exactly BUSY_CYC cycles, starting on the cycle after the confirm write. Writes that arrive during that time are ignored.
- R5: A successful block-lock operation sets the bit of the block chosen by the top log2(NBLK) address bits of the confirm write, and leaves every other bit unchanged.
- R6: A block-lock attempt made while the freeze bit is set, or while `hv_rst` is low, sets bits 1 and 4 and changes no lock.
- R7: A clear attempt made while the freeze bit is set, or while `hv_rst` is low, sets bits 1 and 5 and changes no lock.
- R8: Any lock operation made with `vpp_ok` low sets bit 3 together with the error bit of its kind: bit 4 for a set, bit 5 for a clear. No lock changes.
- R9: A successful clear drops all block lock bits in the same cycle.
- R10: Setting the freeze bit needs `hv_rst` high. Without it, bits 1 and 4 are set. Once the freeze bit is set, it stays set until reset.
- R11: Error bits 1, 3, 4 and 5 stay set until 0x50 is written from idle. That write clears all four and does not change the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; top bits select the block |
| wr_data | input | 8 | Command byte |
| hv_rst | input | 1 | High-voltage reset-pin qualifier present |
| vpp_ok | input | 1 | Program voltage above its lockout level |
| rd_data | output | 8 | Read data: status word or 0x00 |
| ready | output | 1 | 1 when no operation is running |
| blk_lock | output | NBLK | Block lock bits |
| perm_lock | output | 1 | Freeze bit |

## Verification
Results fall into two timing groups.

- **Results due on the next edge.** A rejected confirm byte changes the status word on the edge that samples the write, and so does a clear-status or read-mode command. The failed or successful confirm itself drops `ready` on that same edge.
- **Results due at the end of the operation.** Lock-bit changes and error bits appear BUSY_CYC edges after the confirm, at the moment `ready` rises.

A behavioural reference model advances on every rising edge and is compared with all outputs at each falling edge. The directed checks count falling edges from the confirm write. They sample both one cycle before and at the cycle when `ready` is due to return.

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
  parameter int NBLK     = 8,
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hv_rst,
  input  logic              vpp_ok,
  output logic [7:0]        rd_data,
  output logic              ready,
  output logic [NBLK-1:0]   blk_lock,
  output logic              perm_lock
);

  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  localparam logic [7:0] C_SETUP = 8'h60, C_SETB = 8'h01, C_SETP = 8'hF1,
                         C_CLRB  = 8'hD0, C_CLRS = 8'h50, C_RDS  = 8'h70;
  localparam logic [7:0] E_PROT = 8'h02, E_VLOW = 8'h08, E_SET = 8'h10, E_CLR = 8'h20;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_BUSY} state_t;

  state_t           state;
  logic             stat_mode;
  logic [7:0]       err_r;
  logic [7:0]       op_code, op_err;
  logic [BLK_W-1:0] op_blk;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       cf_err;
  logic             cf_valid;

  wire [BLK_W-1:0] sel_blk = wr_addr[ADDR_W-1 -: BLK_W];
  wire             blocked = perm_lock | ~hv_rst;
  wire [7:0]       v_err   = vpp_ok ? 8'h00 : E_VLOW;

  always_comb begin
    cf_valid = 1'b1;
    cf_err   = 8'h00;
    case (wr_data)
      C_SETB: begin
        cf_err = (blocked ? E_PROT : 8'h00) | v_err;
        if (cf_err != 8'h00) cf_err = cf_err | E_SET;
      end
      C_SETP: begin
        cf_err = (hv_rst ? 8'h00 : E_PROT) | v_err;
        if (cf_err != 8'h00) cf_err = cf_err | E_SET;
      end
      C_CLRB: begin
        cf_err = (blocked ? E_PROT : 8'h00) | v_err;
        if (cf_err != 8'h00) cf_err = cf_err | E_CLR;
      end
      default: cf_valid = 1'b0;
    endcase
  end

  assign ready   = (state != S_BUSY);
  assign rd_data = stat_mode ? ({ready, 7'b0} | err_r) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stat_mode <= 1'b0;
      err_r     <= 8'h00;
      op_code   <= 8'h00;
      op_err    <= 8'h00;
      op_blk    <= '0;
      cnt       <= '0;
      blk_lock  <= '0;
      perm_lock <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wr_en) begin
          case (wr_data)
            C_SETUP: begin state <= S_SETUP; stat_mode <= 1'b1; end
            C_RDS:   stat_mode <= 1'b1;
            C_CLRS:  err_r <= 8'h00;
            default: stat_mode <= 1'b0;
          endcase
        end
        S_SETUP: if (wr_en) begin
          if (cf_valid) begin
            state   <= S_BUSY;
            op_code <= wr_data;
            op_err  <= cf_err;
            op_blk  <= sel_blk;
            cnt     <= CNT_W'(BUSY_CYC - 1);
          end else begin
            state <= S_IDLE;
            err_r <= err_r | E_SET | E_CLR;
          end
        end
        S_BUSY: begin
          if (cnt == '0) begin
            state <= S_IDLE;
            if (op_err != 8'h00) err_r <= err_r | op_err;
            else if (op_code == C_SETB) blk_lock[op_blk] <= 1'b1;
            else if (op_code == C_SETP) perm_lock <= 1'b1;
            else blk_lock <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> perm_lock);

  // R7
  perm_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> ((blk_lock & $past(blk_lock)) == $past(blk_lock)));

  // R4
  lock_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_lock) |-> $rose(ready));

  // R4
  confirm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETUP && wr_en && cf_valid) |=> !ready);

  // R3
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETUP && wr_en && !cf_valid) |=> (ready && err_r[5] && err_r[4]));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_r[5] && !(wr_en && state == S_IDLE && wr_data == C_CLRS)) |=> err_r[5]);

  // R4
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) |-> (int'(cnt) < BUSY_CYC));

endmodule

// File: tb/test_flash_lock_ctrl.sv
module test_flash_lock_ctrl;
  localparam int NBLK = 8, ADDR_W = 8, B = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, hv_rst = 1'b1, vpp_ok = 1'b1;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic ready, perm_lock;
  logic [NBLK-1:0] blk_lock;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  flash_lock_ctrl #(.NBLK(NBLK), .ADDR_W(ADDR_W), .BUSY_CYC(B)) i_flash_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hv_rst(hv_rst), .vpp_ok(vpp_ok), .rd_data(rd_data), .ready(ready),
    .blk_lock(blk_lock), .perm_lock(perm_lock));

  // behavioural reference model
  int m_state, m_cnt, m_blk;
  bit m_stat, m_perm;
  logic [7:0] m_err, m_code, m_fe;
  logic [NBLK-1:0] m_lock;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_stat = 0; m_err = 0; m_lock = 0; m_perm = 0; m_cnt = 0;
    end else if (m_state == 2) begin
      if (m_cnt == 1) begin
        m_state = 0;
        if (m_fe != 0) m_err = m_err | m_fe;
        else if (m_code == 8'h01) m_lock[m_blk] = 1'b1;
        else if (m_code == 8'hF1) m_perm = 1;
        else m_lock = 0;
      end else m_cnt = m_cnt - 1;
    end else if (wr_en) begin
      if (m_state == 0) begin
        if (wr_data == 8'h60) begin m_state = 1; m_stat = 1; end
        else if (wr_data == 8'h70) m_stat = 1;
        else if (wr_data == 8'h50) m_err = 0;
        else m_stat = 0;
      end else begin
        if (wr_data == 8'h01 || wr_data == 8'hF1 || wr_data == 8'hD0) begin
          m_fe = 0;
          if (wr_data == 8'hF1 ? !hv_rst : (m_perm || !hv_rst)) m_fe |= 8'h02;
          if (!vpp_ok) m_fe |= 8'h08;
          if (m_fe != 0) m_fe |= (wr_data == 8'hD0) ? 8'h20 : 8'h10;
          m_code = wr_data; m_blk = int'(wr_addr) / (2 ** ADDR_W / NBLK);
          m_cnt = B; m_state = 2;
        end else begin
          m_state = 0; m_err = m_err | 8'h30;
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    cyc++;
    exp_rd = m_stat ? ({(m_state != 2), 7'b0} | m_err) : 8'h00;
    n_chk++;
    if (rd_data !== exp_rd || ready !== (m_state != 2) || blk_lock !== m_lock || perm_lock !== m_perm) begin
      n_fail++;
      $display("FAIL R4 model cyc %0d: rd %h/%h rdy %b/%b lock %b/%b perm %b/%b", cyc,
               rd_data, exp_rd, ready, (m_state != 2), blk_lock, m_lock, perm_lock, m_perm);
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [ADDR_W-1:0] a = '0);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic op(input logic [7:0] conf, input logic [ADDR_W-1:0] a = '0);
    wr(8'h60);
    wr(conf, a);
    repeat (B) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (500000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd", rd_data, 8'h00);
    chk("R1 reset ready", ready, 1);
    chk("R1 reset locks", {perm_lock, blk_lock}, 0);
    #1 rst_n = 1'b1;
    wr(8'h70);
    chk("R2 status read", rd_data, 8'h80);
    wr(8'hFF);
    chk("R2 array read", rd_data, 8'h00);
    // R5: block 3 via top address bits
    wr(8'h60);
    chk("R2 setup selects status", rd_data, 8'h80);
    wr(8'h01, 8'h60);
    chk("R4 busy after confirm", {ready, rd_data}, {1'b0, 8'h00});
    repeat (B - 1) @(negedge clk); #1;
    chk("R4 still busy", ready, 0);
    @(negedge clk); #1;
    chk("R4 ready returns", ready, 1);
    chk("R5 block 3 set", blk_lock, 8'h08);
    op(8'h01, 8'hE0);
    chk("R5 block 7 set", blk_lock, 8'h88);
    wr(8'h60); wr(8'hFF);
    chk("R3 bad confirm status", {ready, rd_data}, {1'b1, 8'hB0});
    chk("R3 locks kept", blk_lock, 8'h88);
    wr(8'hAA);
    chk("R11 sticky across array mode", rd_data, 8'h00);
    wr(8'h70);
    chk("R11 sticky", rd_data, 8'hB0);
    wr(8'h50);
    chk("R11 clear status", rd_data, 8'h80);
    vpp_ok = 1'b0;
    op(8'hD0);
    chk("R8 clear vpp low", rd_data, 8'hA8);
    chk("R8 locks kept", blk_lock, 8'h88);
    op(8'h01, 8'h20);
    chk("R8 set vpp low", rd_data, 8'hB8);
    vpp_ok = 1'b1; wr(8'h50);
    hv_rst = 1'b0;
    op(8'hD0);
    chk("R7 clear hv low", rd_data, 8'hA2);
    wr(8'h50);
    op(8'h01, 8'h20);
    chk("R6 set hv low", {blk_lock, rd_data}, {8'h88, 8'h92});
    wr(8'h50);
    op(8'hF1);
    chk("R10 perm needs hv", {perm_lock, rd_data}, {1'b0, 8'h92});
    // R4: write during busy ignored
    wr(8'h60); wr(8'hD0);
    wr(8'h50);
    repeat (B) @(negedge clk); #1;
    chk("R4 write in busy ignored", rd_data, 8'hB2);
    hv_rst = 1'b1; wr(8'h50);
    op(8'hD0);
    chk("R9 clear all", {blk_lock, rd_data}, {8'h00, 8'h80});
    op(8'h01, 8'h40);
    chk("R5 block 2 set", blk_lock, 8'h04);
    op(8'hF1);
    chk("R10 perm set", perm_lock, 1);
    op(8'h01, 8'h20);
    chk("R6 set with perm", {blk_lock, rd_data}, {8'h04, 8'h92});
    wr(8'h50);
    op(8'hD0);
    chk("R7 clear with perm", {blk_lock, rd_data}, {8'h04, 8'hA2});
    chk("R10 perm stays", perm_lock, 1);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule